// File: doc/BRIEF.md
# Dual-Port Pixel Output Demultiplexer

This block takes one digitized pixel sample per pixel clock and sends it to one of two registered output ports, A and B. In dual-port mode the samples take turns between the ports, so each port carries half the pixel rate. In single-port mode every sample goes to port A and port B is switched off through a per-bit output enable. A line-start pulse marks the sample that anchors the turn-taking for the line. That anchor goes to A, or to B when the swap control is set. A display pipeline uses swap so that the first active pixel of a line lands on the port it expects.

The block also produces an output data clock for latching port A externally. It models the latency of an upstream pipeline by keeping the valid flags low for the first data sets after reset or a mode change. In single-port mode that is four sets. In dual-port mode it is two port-A sets.

Top module: `pxd_demux`

## Requirements
- R1: After synchronous reset, `a_vld`, `b_vld` and `dclk_out` are low, `b_oe` is all zeros and both data ports read zero.
- R2: Samples that arrive after reset but before the first accepted line start reach neither port.
- R3: In dual-port mode with swap clear, the line-start sample goes to port A. Each later sample of the line goes to the port opposite to the previous sample.
- R4: In dual-port mode with swap set, the line-start sample goes to port B. Alternation then continues as in R3.
- R5: Every accepted line start re-anchors the alternation, whatever number of samples the previous line had.
- R6: In single-port mode every sample goes to port A, `b_vld` stays low and `b_oe` is all zeros. Once dual-port mode is active, `b_oe` is all ones.
- R7: In single-port mode, the first four port-A loads after reset, or after a line start that changes the mode, carry `a_vld` low. A line start that keeps the mode does not restart this count.
- R8: In dual-port mode, the first two port-A loads after reset or a mode change carry `a_vld` low. A port-B load is valid only after those two port-A loads have happened.
- R9: Changes on `dual_mode` or `swap_ports` take effect only at the next accepted line start. That line-start sample already follows the new setting.
- R10: `dclk_out` is high in exactly the cycle that follows each port-A load, whether or not the load is valid. At all other times it is low.
- R11: A line-start pulse without `smp_vld` is ignored. When `smp_vld` is low, nothing is loaded and no valid flag rises.
- R12: A sample presented with `smp_vld` appears on its port, with its valid pulse, in the cycle after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_data | input | DATA_W | Digitized pixel sample |
| smp_vld | input | 1 | Sample strobe, one sample per high cycle |
| line_start | input | 1 | Marks the current sample as the line anchor (qualified by smp_vld) |
| dual_mode | input | 1 | 1 = alternate between A and B, 0 = A only |
| swap_ports | input | 1 | 1 = line anchor goes to port B |
| a_data | output | DATA_W | Port A data, held between loads |
| a_vld | output | 1 | One-cycle pulse: a_data just loaded with valid data |
| b_data | output | DATA_W | Port B data, held between loads |
| b_vld | output | 1 | One-cycle pulse: b_data just loaded with valid data |
| b_oe | output | DATA_W | Per-bit output enable for port B |
| dclk_out | output | 1 | Output data clock, rises between port-A updates |

## Verification
The case hardest to reach from the ports is the dual-port flush boundary. Port B is loaded while only one invalid port-A load has happened, and the valid flags must then be placed exactly against the two-load count. With swap set, the count must also restart even though the anchor went to B. The stimulus reaches both by switching modes at line starts, with lines of odd and even length and with idle gaps between samples. A scoreboard built from the requirements lists which words must come out flagged valid on each port. Mode and swap are also toggled in the middle of a line, and a line-start pulse is given with no sample. This shows that neither disturbs the current line.

// File: rtl/pxd_pkg.sv
package pxd_pkg;
  typedef enum logic {
    PORT_A = 1'b0,
    PORT_B = 1'b1
  } port_e;

  function automatic port_e other_port(input port_e p);
    return (p == PORT_A) ? PORT_B : PORT_A;
  endfunction
endpackage

// File: rtl/pxd_steer.sv
module pxd_steer
  import pxd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  smp_vld,
  input  logic  line_start,
  input  logic  dual_mode,
  input  logic  swap_ports,
  output logic  accept,
  output port_e dest,
  output logic  eff_dual,
  output logic  mode_chg
);
  logic  started_q;
  logic  dual_q;
  logic  swap_q;
  port_e next_q;
  logic  anchor;
  logic  eff_swap;
  port_e pick;

  assign anchor   = smp_vld && line_start;
  assign eff_dual = anchor ? dual_mode  : dual_q;
  assign eff_swap = anchor ? swap_ports : swap_q;
  assign accept   = smp_vld && (line_start || started_q);
  assign mode_chg = anchor && (dual_mode != dual_q);

  always_comb begin
    if (!eff_dual)
      pick = PORT_A;
    else if (anchor)
      pick = eff_swap ? PORT_B : PORT_A;
    else
      pick = next_q;
  end
  assign dest = pick;

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      dual_q    <= 1'b0;
      swap_q    <= 1'b0;
      next_q    <= PORT_A;
    end else if (accept) begin
      started_q <= 1'b1;
      next_q    <= other_port(pick);
      if (anchor) begin
        dual_q <= dual_mode;
        swap_q <= swap_ports;
      end
    end
  end
endmodule

// File: rtl/pxd_flush.sv
module pxd_flush #(
  parameter int FLUSH_SGL = 4,
  parameter int FLUSH_DUL = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic a_load,
  input  logic mode_chg,
  input  logic eff_dual,
  output logic a_ok,
  output logic b_ok
);
  localparam int CNT_MAX = (FLUSH_SGL > FLUSH_DUL) ? FLUSH_SGL : FLUSH_DUL;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] THR_S = CNT_W'(FLUSH_SGL);
  localparam logic [CNT_W-1:0] THR_D = CNT_W'(FLUSH_DUL);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] base;

  assign base = mode_chg ? '0 : cnt_q;
  assign a_ok = base >= (eff_dual ? THR_D : THR_S);
  assign b_ok = base >= THR_D;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (a_load)
      cnt_q <= (base == MAX_V) ? MAX_V : base + 1'b1;
    else if (mode_chg)
      cnt_q <= '0;
  end
endmodule

// File: rtl/pxd_dclk.sv
module pxd_dclk (
  input  logic clk,
  input  logic rst,
  input  logic a_load,
  output logic dclk_out
);
  logic load_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q   <= 1'b0;
      dclk_out <= 1'b0;
    end else begin
      load_q   <= a_load;
      dclk_out <= load_q;
    end
  end
endmodule

// File: rtl/pxd_demux.sv
module pxd_demux
  import pxd_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int FLUSH_SGL = 4,
  parameter int FLUSH_DUL = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_vld,
  input  logic              line_start,
  input  logic              dual_mode,
  input  logic              swap_ports,
  output logic [DATA_W-1:0] a_data,
  output logic              a_vld,
  output logic [DATA_W-1:0] b_data,
  output logic              b_vld,
  output logic [DATA_W-1:0] b_oe,
  output logic              dclk_out
);
  logic  accept;
  port_e dest;
  logic  eff_dual;
  logic  mode_chg;
  logic  a_load;
  logic  b_load;
  logic  a_ok;
  logic  b_ok;

  pxd_steer u_steer (
    .clk        (clk),
    .rst        (rst),
    .smp_vld    (smp_vld),
    .line_start (line_start),
    .dual_mode  (dual_mode),
    .swap_ports (swap_ports),
    .accept     (accept),
    .dest       (dest),
    .eff_dual   (eff_dual),
    .mode_chg   (mode_chg)
  );

  assign a_load = accept && (dest == PORT_A);
  assign b_load = accept && (dest == PORT_B);

  pxd_flush #(
    .FLUSH_SGL (FLUSH_SGL),
    .FLUSH_DUL (FLUSH_DUL)
  ) u_flush (
    .clk      (clk),
    .rst      (rst),
    .a_load   (a_load),
    .mode_chg (mode_chg),
    .eff_dual (eff_dual),
    .a_ok     (a_ok),
    .b_ok     (b_ok)
  );

  pxd_dclk u_dclk (
    .clk      (clk),
    .rst      (rst),
    .a_load   (a_load),
    .dclk_out (dclk_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_data <= '0;
      b_data <= '0;
      a_vld  <= 1'b0;
      b_vld  <= 1'b0;
      b_oe   <= '0;
    end else begin
      a_vld <= a_load && a_ok;
      b_vld <= b_load && b_ok;
      if (a_load) a_data <= smp_data;
      if (b_load) b_data <= smp_data;
      if (accept && line_start) b_oe <= {DATA_W{eff_dual}};
    end
  end
endmodule

// File: rtl/pxd_demux_chk.sv
module pxd_demux_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] smp_data,
  input logic              smp_vld,
  input logic [DATA_W-1:0] a_data,
  input logic              a_vld,
  input logic              b_vld,
  input logic [DATA_W-1:0] b_oe,
  input logic              dclk_out
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!a_vld && !b_vld && !dclk_out && b_oe == '0));

  // R3
  one_port_per_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !(a_vld && b_vld));

  // R6
  b_quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    b_vld |-> (b_oe == {DATA_W{1'b1}}));

  // R6
  b_oe_uniform_chk: assert property (@(posedge clk) disable iff (rst)
    (b_oe == '0) || (b_oe == {DATA_W{1'b1}}));

  // R10
  dclk_after_load_chk: assert property (@(posedge clk) disable iff (rst)
    a_vld |=> dclk_out);

  // R11
  idle_no_output_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> (!a_vld && !b_vld));

  // R12
  a_latency_chk: assert property (@(posedge clk) disable iff (rst)
    a_vld |-> (a_data == $past(smp_data)));
endmodule

bind pxd_demux pxd_demux_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .smp_data (smp_data),
  .smp_vld  (smp_vld),
  .a_data   (a_data),
  .a_vld    (a_vld),
  .b_vld    (b_vld),
  .b_oe     (b_oe),
  .dclk_out (dclk_out)
);

// File: tb/test_pxd_demux.sv
module test_pxd_demux;
  localparam int W      = 10;
  localparam int CLK_PS = 10;
  localparam int DEPTH  = 4096;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] smp_data = '0;
  logic         smp_vld = 1'b0, line_start = 1'b0, dual_mode = 1'b0, swap_ports = 1'b0;
  logic [W-1:0] a_data, b_data, b_oe;
  logic         a_vld, b_vld, dclk_out;

  int n_tests = 0, n_fail = 0, cyc = 0, n_a = 0, n_b = 0;
  bit exp_dclk [DEPTH];
  logic [W-1:0] qa [$];
  logic [W-1:0] qb [$];
  logic [W-1:0] seed = 10'd17;
  logic timeout = 1'b0;

  // reference state derived from the requirements
  bit m_started = 0, m_dual = 0, m_swap = 0, m_nxtb = 0;
  int m_cnt = 0;

  pxd_demux #(.DATA_W(W)) i_pxd_demux (
    .clk(clk), .rst(rst), .smp_data(smp_data), .smp_vld(smp_vld),
    .line_start(line_start), .dual_mode(dual_mode), .swap_ports(swap_ports),
    .a_data(a_data), .a_vld(a_vld), .b_data(b_data), .b_vld(b_vld),
    .b_oe(b_oe), .dclk_out(dclk_out)
  );

  always #(CLK_PS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected results
  task automatic drive(input bit v, input bit ls, input bit dm, input bit sw);
    bit ed, tob, chg;
    int base;
    @(posedge clk); #1;
    seed = seed + 10'd37;
    smp_data = seed; smp_vld = v; line_start = ls; dual_mode = dm; swap_ports = sw;
    if (v && (ls || m_started)) begin
      ed   = ls ? dm : m_dual;               // R9: settings latch at line start
      chg  = ls && (dm != m_dual);
      tob  = ed && (ls ? sw : m_nxtb);       // R3 R4 R5
      base = chg ? 0 : m_cnt;
      if (!tob) begin
        if (base >= (ed ? 2 : 4)) qa.push_back(seed);  // R7 R8
        m_cnt = (base >= 4) ? 4 : base + 1;
        if (cyc + 2 < DEPTH) exp_dclk[cyc + 2] = 1'b1; // R10
      end else begin
        if (base >= 2) qb.push_back(seed);             // R8
        m_cnt = base;
      end
      m_nxtb = !tob;
      m_started = 1;
      if (ls) begin m_dual = dm; m_swap = sw; end
    end
  endtask

  task automatic line(input int n, input bit dm, input bit sw, input bit gaps);
    drive(1, 1, dm, sw);
    for (int i = 1; i < n; i++) begin
      if (gaps && (i % 3 == 0)) drive(0, 0, dm, sw);
      drive(1, 0, dm, sw);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, dual_mode, swap_ports);
  endtask

  // monitor: pops the scoreboard on each valid pulse (R12 latency, R3/R6 routing)
  always @(negedge clk) begin
    if (!rst) begin
      if (a_vld) begin
        n_a++;
        if (qa.size() == 0) check("R12 unexpected a_vld", 1, 0);
        else check("R12 port A word", a_data, qa.pop_front());
      end
      if (b_vld) begin
        n_b++;
        if (qb.size() == 0) check("R6/R8 unexpected b_vld", 1, 0);
        else check("R4 port B word", b_data, qb.pop_front());
      end
      if (cyc < DEPTH) check("R10 dclk_out", dclk_out, exp_dclk[cyc]);
    end
  end

  task automatic run;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 a_vld", a_vld, 0); check("R1 b_vld", b_vld, 0);
    check("R1 dclk", dclk_out, 0); check("R1 b_oe", b_oe, 0);
    check("R1 a_data", a_data, 0); check("R1 b_data", b_data, 0);
    // R2 samples before any line start
    drive(1, 0, 0, 0); drive(1, 0, 0, 0); drive(1, 0, 1, 1); idle(3);
    check("R2 no output before line start", n_a + n_b, 0);
    // R6 R7 single-port line, four-load flush
    line(8, 0, 0, 0); idle(2);
    check("R6 b_oe off in single", b_oe, 0);
    check("R7 valid count after flush", n_a, 4);
    // R7 same mode: no restart; R9 mid-line mode toggle ignored
    drive(1, 1, 0, 0); drive(1, 0, 0, 0);
    drive(1, 0, 1, 0); drive(1, 0, 1, 1); idle(2);
    check("R9 single kept mid-line", n_a, 8);
    check("R6 no B in single", n_b, 0);
    // R3 R8 dual-port, swap clear, with gaps
    line(10, 1, 0, 1); idle(2);
    check("R6 b_oe on in dual", b_oe, {W{1'b1}});
    // R5 odd-length line then re-anchor; R11 stray line start
    line(5, 1, 0, 0);
    drive(0, 1, 1, 1); drive(1, 0, 1, 1);
    line(6, 1, 0, 0); idle(2);
    // R4 swap set, same mode keeps flush
    line(7, 1, 1, 1);
    // R8 mode change with swap anchor on B restarts dual flush
    line(3, 0, 0, 0); line(9, 1, 1, 0); idle(2);
    // R7 back to single restarts four-load flush
    line(6, 0, 0, 1); idle(3);
    check("R6 b_oe off again", b_oe, 0);
    check("R7 R8 scoreboard A drained", qa.size(), 0);
    check("R8 scoreboard B drained", qb.size(), 0);
  endtask

  initial begin
    fork
      run;
      begin repeat (20000) @(posedge clk); timeout = 1'b1; end
    join_any
    disable fork;
    if (timeout) check("watchdog", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule